// File: doc/BRIEF.md
# Multi-source edge interrupt controller

This block gathers interrupt requests from a set of port-C channels, from two single-cycle event inputs coming from a pattern detector and a change detector, and from a software trigger. Each source owns a sticky flag. The OR of all flags is registered and drives a level interrupt output. An identical copy of that output drives a pin, so that external devices can fire at the same moment as the host.

Each channel watches two asynchronous input lines, bit 0 and bit 4 of its port. A control register per channel chooses which lines are observed and which edge counts. The host reaches all state through a byte-wide register port. Channel control registers sit at addresses 0 to NUM_CH-1. The software-trigger strobe is at address NUM_CH and the global clear strobe is at NUM_CH+1. Writes to either strobe address do their work whatever the data value is.

Top module: `irq_edge_ctrl`

## Requirements
- R1: After reset, every flag is 0, `irq_out` and `irq_ext` are 0, and every control field reads back as 0.
- R2: A channel control register holds the flag in bit 7, the edge select in bit 6 and the line mode in bits 5:4. Bits 6:4 read back as they were last written.
- R3: An edge select of 1 makes rising edges count and an edge select of 0 makes falling edges count. An edge of the opposite direction never sets the flag.
- R4: Mode 2'b10 observes line 0 only, so edges on line 4 are ignored.
- R5: Mode 2'b01 observes both lines, and a qualifying edge on either line sets the flag.
- R6: Modes 2'b00 and 2'b11 disable the channel, so no edge sets its flag.
- R7: A set flag stays set, and edges that arrive while it is set are dropped. After it is cleared, no earlier edge raises it again.
- R8: Writing 1 to bit 7 of a channel register clears that flag. Writing 0 to bit 7 leaves it unchanged.
- R9: In channel register 0, bit 0 enables the pattern-event source and bit 1 is its flag, while bit 2 enables the change-event source and bit 3 is its flag. An enabled event pulse sets its flag, and writing 1 to a flag bit clears that flag. While a source is disabled, its pulse has no effect.
- R10: Any write to address NUM_CH sets the software flag, which reads back as bit 0 at that address.
- R11: Any write to address NUM_CH+1 clears every flag. The interrupt output then falls one cycle later.
- R12: `irq_out` is the registered OR of all flags. It rises one clock after a flag sets, and `irq_ext` always equals it.
- R13: A port-line edge passes through a two-flop synchronizer. Its flag reads as 1 three clocks after the edge and `irq_out` rises after the fourth clock.
- R14: Flags of different sources can be pending together, and clearing one leaves the others untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pc_line0 | input | NUM_CH | Port bit 0 of each channel, asynchronous |
| pc_line4 | input | NUM_CH | Port bit 4 of each channel, asynchronous |
| pm_evt | input | 1 | Single-cycle pattern-detector event, synchronous |
| cs_evt | input | 1 | Single-cycle change-detector event, synchronous |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq_out | output | 1 | Level interrupt request to the host |
| irq_ext | output | 1 | Copy of the interrupt request for external devices |

## Verification
The assertions assume three things about the inputs. The event inputs are synchronous to `clk`. A write strobe lasts one cycle and carries a stable address. Port lines sit low while reset is active, because a line held high through reset would look like a rising edge once reset is released. The bench keeps to these assumptions. It changes port lines only at falling clock edges, pulses the event inputs for exactly one cycle, holds every line low through reset, and drives each line back low before it moves to another channel setting. It also steers clear of a clear write and an edge landing in the same cycle, which is the single case where the set-wins priority decides the result.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  localparam int DATA_W    = 8;
  localparam int BIT_FLAG  = 7;
  localparam int BIT_EDGE  = 6;
  localparam int MODE_HI   = 5;
  localparam int MODE_LO   = 4;

  localparam int AUX_PM_EN   = 0;
  localparam int AUX_PM_FLAG = 1;
  localparam int AUX_CS_EN   = 2;
  localparam int AUX_CS_FLAG = 3;

  localparam logic [1:0] MODE_LINE0 = 2'b10;
  localparam logic [1:0] MODE_BOTH  = 2'b01;

  typedef struct packed {
    logic       edge_rise;
    logic [1:0] mode;
  } chan_cfg_t;

endpackage

// File: rtl/irq_line_edge.sv
module irq_line_edge
  import irq_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LINES       = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] lines_raw,
  input  chan_cfg_t        cfg,
  output logic             evt
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [LINES-1:0] rise_w;
  logic [LINES-1:0] fall_w;
  logic [LINES-1:0] pick_w;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] chain_q;
    logic [SYNC_STAGES-1:0] chain_d;
    logic                   last_q;

    always_comb begin
      chain_d = {chain_q[TOP-1:0], lines_raw[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        last_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        last_q  <= chain_q[TOP];
      end
    end

    assign rise_w[g] = chain_q[TOP] & ~last_q;
    assign fall_w[g] = ~chain_q[TOP] & last_q;
  end

  always_comb begin
    pick_w = cfg.edge_rise ? rise_w : fall_w;
    unique case (cfg.mode)
      MODE_LINE0: evt = pick_w[0];
      MODE_BOTH:  evt = |pick_w;
      default:    evt = 1'b0;
    endcase
  end

endmodule

// File: rtl/irq_sticky_flag.sv
module irq_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_d;

  always_comb begin
    flag_d = flag_o;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= flag_d;
  end

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o); // R7
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o); // R8
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R14

endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] pc_line0,
  input  logic [NUM_CH-1:0] pc_line4,
  input  logic              pm_evt,
  input  logic              cs_evt,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out,
  output logic              irq_ext
);

  localparam logic [ADDR_W-1:0] SW_ADDR  = ADDR_W'(NUM_CH);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(NUM_CH + 1);
  localparam int               NFLAGS   = NUM_CH + 3;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  // write decode
  logic [NUM_CH-1:0] wr_ch;
  logic              wr_sw, clr_all;
  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      wr_ch[n] = bus_wr && (bus_addr == ADDR_W'(n));
    end
    wr_sw   = bus_wr && (bus_addr == SW_ADDR);
    clr_all = bus_wr && (bus_addr == CLR_ADDR);
  end

  // control registers
  chan_cfg_t cfg_q [NUM_CH];
  chan_cfg_t cfg_d [NUM_CH];
  logic      pm_en_q, pm_en_d, cs_en_q, cs_en_d;

  always_comb begin
    for (int n = 0; n < NUM_CH; n++) begin
      cfg_d[n] = cfg_q[n];
      if (wr_ch[n]) begin
        cfg_d[n].edge_rise = bus_wdata[BIT_EDGE];
        cfg_d[n].mode      = bus_wdata[MODE_HI:MODE_LO];
      end
    end
    pm_en_d = wr_ch[0] ? bus_wdata[AUX_PM_EN] : pm_en_q;
    cs_en_d = wr_ch[0] ? bus_wdata[AUX_CS_EN] : cs_en_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      for (int n = 0; n < NUM_CH; n++) cfg_q[n] <= '0;
      pm_en_q <= 1'b0;
      cs_en_q <= 1'b0;
    end else begin
      for (int n = 0; n < NUM_CH; n++) cfg_q[n] <= cfg_d[n];
      pm_en_q <= pm_en_d;
      cs_en_q <= cs_en_d;
    end
  end

  // channel sources
  logic [NUM_CH-1:0] ch_evt, ch_flag;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    irq_line_edge #(.SYNC_STAGES(SYNC_STAGES), .LINES(2)) u_edge (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .lines_raw ({pc_line4[g], pc_line0[g]}),
      .cfg       (cfg_q[g]),
      .evt       (ch_evt[g])
    );

    irq_sticky_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .set_i  (ch_evt[g]),
      .clr_i  (clr_all | (wr_ch[g] & bus_wdata[BIT_FLAG])),
      .flag_o (ch_flag[g])
    );

    AST_CH_DISABLED: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ((cfg_q[g].mode[1] == cfg_q[g].mode[0]) && !ch_flag[g]) |=> !ch_flag[g]); // R6
  end

  // detector and software sources
  logic pm_flag, cs_flag, sw_flag;

  irq_sticky_flag u_pm_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (pm_evt & pm_en_q),
    .clr_i  (clr_all | (wr_ch[0] & bus_wdata[AUX_PM_FLAG])),
    .flag_o (pm_flag)
  );

  irq_sticky_flag u_cs_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (cs_evt & cs_en_q),
    .clr_i  (clr_all | (wr_ch[0] & bus_wdata[AUX_CS_FLAG])),
    .flag_o (cs_flag)
  );

  irq_sticky_flag u_sw_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_i  (wr_sw),
    .clr_i  (clr_all),
    .flag_o (sw_flag)
  );

  // interrupt output
  logic [NFLAGS-1:0] all_flags;
  logic              irq_d, irq_q;

  always_comb begin
    all_flags = {ch_flag, pm_flag, cs_flag, sw_flag};
    irq_d     = |all_flags;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_out = irq_q;
  assign irq_ext = irq_q;

  // read mux
  always_comb begin
    bus_rdata = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == ADDR_W'(n)) begin
        bus_rdata[BIT_FLAG]        = ch_flag[n];
        bus_rdata[BIT_EDGE]        = cfg_q[n].edge_rise;
        bus_rdata[MODE_HI:MODE_LO] = cfg_q[n].mode;
        if (n == 0) begin
          bus_rdata[AUX_CS_FLAG] = cs_flag;
          bus_rdata[AUX_CS_EN]   = cs_en_q;
          bus_rdata[AUX_PM_FLAG] = pm_flag;
          bus_rdata[AUX_PM_EN]   = pm_en_q;
        end
      end
    end
    if (bus_addr == SW_ADDR) bus_rdata = {{(DATA_W-1){1'b0}}, sw_flag};
  end

  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|ch_flag || pm_flag || cs_flag || sw_flag) |=> irq_out); // R12
  AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_sw |=> sw_flag); // R10
  AST_CLR_SW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_all |=> !sw_flag); // R11
  AST_PM_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!pm_en_q && !pm_flag && !wr_ch[0]) |=> !pm_flag); // R9

endmodule

// File: tb/irq_edge_ctrl_test.sv
module irq_edge_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] pc_line0, pc_line4;
  logic       pm_evt, cs_evt;
  logic [2:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       irq_out, irq_ext;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  irq_edge_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pc_line0(pc_line0), .pc_line4(pc_line4),
    .pm_evt(pm_evt), .cs_evt(cs_evt), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out), .irq_ext(irq_ext)
  );

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic chk_rd(string tag, logic [2:0] a, logic [7:0] exp);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic chk_irq(string tag, logic exp);
    chk({tag, " irq_out"}, {7'b0, irq_out}, {7'b0, exp});
    chk({tag, " irq_ext"}, {7'b0, irq_ext}, {7'b0, exp});
  endtask

  task automatic pulse_pm();
    pm_evt = 1'b1; step(1); pm_evt = 1'b0;
  endtask

  task automatic pulse_cs();
    cs_evt = 1'b1; step(1); cs_evt = 1'b0;
  endtask

  task automatic t_reset();
    chk_irq("R1 reset", 1'b0);
    for (int a = 0; a < 5; a++) chk_rd("R1 reset regs", 3'(a), 8'h00);
  endtask

  task automatic t_layout();
    wr(3'd1, 8'h50); chk_rd("R2 readback ch1", 3'd1, 8'h50);
    wr(3'd2, 8'hE0); chk_rd("R2 readback ch2, flag write", 3'd2, 8'h60);
  endtask

  task automatic t_rise_latency();
    wr(3'd0, 8'h60);
    pc_line0[0] = 1'b1; step(3);
    chk_rd("R13 flag after 3 clocks", 3'd0, 8'hE0);
    chk_irq("R13 irq not yet", 1'b0);
    step(1);
    chk_irq("R12 irq after flag", 1'b1);
    wr(3'd0, 8'hE0);
    chk_rd("R8 write 1 clears", 3'd0, 8'h60);
    step(1);
    chk_irq("R12 irq falls", 1'b0);
    pc_line0[0] = 1'b0; step(4);
    chk_rd("R3 falling ignored in rise mode", 3'd0, 8'h60);
  endtask

  task automatic t_fall();
    wr(3'd0, 8'h20);
    pc_line0[0] = 1'b1; step(4);
    chk_rd("R3 rising ignored in fall mode", 3'd0, 8'h20);
    pc_line0[0] = 1'b0; step(4);
    chk_rd("R3 falling sets", 3'd0, 8'hA0);
    wr(3'd0, 8'hA0);
    chk_rd("R3 cleared", 3'd0, 8'h20);
  endtask

  task automatic t_lines();
    pc_line4[2] = 1'b1; step(4);
    chk_rd("R4 line4 ignored", 3'd2, 8'h60);
    pc_line0[2] = 1'b1; step(4);
    chk_rd("R4 line0 sets", 3'd2, 8'hE0);
    wr(3'd2, 8'hE0);
    pc_line0[2] = 1'b0; pc_line4[2] = 1'b0; step(4);
    chk_rd("R4 cleared", 3'd2, 8'h60);
    pc_line4[1] = 1'b1; step(4);
    chk_rd("R5 line4 sets", 3'd1, 8'hD0);
    wr(3'd1, 8'hD0);
    chk_rd("R5 cleared", 3'd1, 8'h50);
    pc_line0[1] = 1'b1; step(4);
    chk_rd("R5 line0 sets", 3'd1, 8'hD0);
    wr(3'd1, 8'hD0);
    pc_line0[1] = 1'b0; pc_line4[1] = 1'b0; step(4);
    chk_rd("R5 falling ignored", 3'd1, 8'h50);
  endtask

  task automatic t_disabled();
    wr(3'd2, 8'h40);
    pc_line0[2] = 1'b1; step(4);
    chk_rd("R6 mode 00 off", 3'd2, 8'h40);
    chk_irq("R6 no irq", 1'b0);
    wr(3'd2, 8'h70);
    pc_line0[2] = 1'b0; step(4);
    pc_line0[2] = 1'b1; pc_line4[2] = 1'b1; step(4);
    chk_rd("R6 mode 11 off", 3'd2, 8'h70);
    pc_line0[2] = 1'b0; pc_line4[2] = 1'b0; step(4);
  endtask

  task automatic t_sticky();
    wr(3'd3, 8'h60);
    pc_line0[3] = 1'b1; step(4);
    chk_rd("R7 first edge", 3'd3, 8'hE0);
    pc_line0[3] = 1'b0; step(4);
    pc_line0[3] = 1'b1; step(4);
    chk_rd("R7 still set", 3'd3, 8'hE0);
    wr(3'd3, 8'hE0); step(4);
    chk_rd("R7 no pending edge", 3'd3, 8'h60);
    chk_irq("R7 irq quiet", 1'b0);
  endtask

  task automatic t_write_zero();
    pc_line0[3] = 1'b0; step(4);
    pc_line0[3] = 1'b1; step(4);
    chk_rd("R8 flag set", 3'd3, 8'hE0);
    wr(3'd3, 8'h60);
    chk_rd("R8 write 0 keeps flag", 3'd3, 8'hE0);
    wr(3'd3, 8'hE0);
    chk_rd("R8 cleared", 3'd3, 8'h60);
    pc_line0[3] = 1'b0; step(4);
  endtask

  task automatic t_aux();
    wr(3'd0, 8'h65);
    pulse_pm();
    chk_rd("R9 pattern flag", 3'd0, 8'h67);
    pulse_cs();
    chk_rd("R9 change flag", 3'd0, 8'h6F);
    wr(3'd0, 8'h67);
    chk_rd("R9 clear pattern only", 3'd0, 8'h6D);
    wr(3'd0, 8'h6D);
    chk_rd("R9 clear change", 3'd0, 8'h65);
    wr(3'd0, 8'h60);
    pulse_pm(); pulse_cs();
    chk_rd("R9 disabled sources", 3'd0, 8'h60);
  endtask

  task automatic t_soft();
    wr(3'd4, 8'h00);
    chk_rd("R10 soft flag", 3'd4, 8'h01);
    step(1);
    chk_irq("R12 soft irq", 1'b1);
  endtask

  task automatic t_multi();
    wr(3'd0, 8'h65);
    pc_line0[0] = 1'b1; pc_line0[1] = 1'b1; pm_evt = 1'b1;
    step(1); pm_evt = 1'b0; step(3);
    chk_rd("R14 ch0 + pattern", 3'd0, 8'hE7);
    chk_rd("R14 ch1", 3'd1, 8'hD0);
    wr(3'd1, 8'hD0);
    chk_rd("R14 ch1 cleared", 3'd1, 8'h50);
    chk_rd("R14 ch0 untouched", 3'd0, 8'hE7);
    chk_rd("R14 soft untouched", 3'd4, 8'h01);
    wr(3'd5, 8'h3C);
    chk_rd("R11 ch0 cleared", 3'd0, 8'h65);
    chk_rd("R11 soft cleared", 3'd4, 8'h00);
    step(1);
    chk_irq("R11 irq falls", 1'b0);
    pc_line0[0] = 1'b0; pc_line0[1] = 1'b0; step(4);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    rst_n = 1'b0; pc_line0 = '0; pc_line4 = '0; pm_evt = 1'b0; cs_evt = 1'b0;
    bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    step(3);
    rst_n = 1'b1;
    step(4);
    t_reset();
    t_layout();
    t_rise_latency();
    t_fall();
    t_lines();
    t_disabled();
    t_sticky();
    t_write_zero();
    t_aux();
    t_soft();
    t_multi();
    summary();
  end

endmodule